// File: doc/BRIEF.md
# Reserved Load and Conditional Store Unit

This unit executes the two atomic-memory instructions of a small RISC core: a load that places a reservation, and a store that writes only if that reservation still holds. The core hands it one decoded request at a time. Each request carries a 6-bit major opcode, the base register value, the store-data register value and the low 26 instruction bits that hold the immediate fields. The unit computes the effective address and runs one or two transfers on a single-word memory port that uses a request/ready handshake. It finishes with a one-cycle done pulse that carries the load data or the store-conditional success flag.

The unit holds one reservation, made of an address and the word that the reserving load returned. An address of all ones means no reservation. A conditional store goes to memory only when its address equals the reserved address. It then reads the word and writes it back under a held lock, and only if the word still equals the recorded value. Every conditional store ends the reservation. Reset, exception entry, return from exception and an MMU fault also end it.

Top module: `lrsc_unit`

## Requirements
- R1: Only major opcode 0x1B (reserving load) and 0x33 (conditional store) are accepted. With any other opcode, a valid request starts no memory transfer, gives no done pulse and leaves the reservation unchanged.
- R2: A reserving load reads the word at base plus sign-extended insn[15:0] in one memory read. The word appears on `ld_data` in the done cycle.
- R3: A reserving load records both its address and the word it read as the reservation.
- R4: A conditional store addresses base plus the sign extension of the 16-bit offset {insn[25:21], insn[10:0]}, with the high field placed above the low field.
- R5: A conditional store whose address differs from the reserved address, or that runs with no reservation, returns flag 0 and makes no memory transfer.
- R6: A conditional store with a matching address performs a read and then a write, with `mem_lock` held through both. It writes the store data and returns flag 1 when the word read equals the recorded value.
- R7: A conditional store with a matching address whose read returns a value other than the recorded one makes exactly one transfer (the read), leaves memory unchanged and returns flag 0.
- R8: Every conditional store, whether it succeeds or fails, ends the reservation, so a repeated store to the same address fails without a memory transfer.
- R9: Reset, `exc_enter`, `exc_return` and `mmu_fault` end the reservation. A cancel in the same cycle as the read that completes a reserving load wins, and no reservation remains.
- R10: `done` is high for exactly one cycle per accepted instruction, and `sc_ok` is valid in that cycle. `req_ready` is high only while the unit is idle.
- R11: While `mem_req` is high and `mem_ready` is low, the request stays asserted with a stable address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Decoded request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| req_opcode | input | 6 | Major opcode |
| req_base | input | ADDR_W | Base register value |
| req_wdata | input | DATA_W | Store-data register value |
| req_insn | input | 26 | Instruction bits 25:0 |
| exc_enter | input | 1 | Exception entry, cancels reservation |
| exc_return | input | 1 | Return from exception, cancels reservation |
| mmu_fault | input | 1 | MMU fault, cancels reservation |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_lock | output | 1 | Bus held for the atomic read-write pair |
| mem_addr | output | ADDR_W | Transfer address |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Transfer completes this cycle |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready |
| done | output | 1 | One-cycle completion pulse |
| ld_data | output | DATA_W | Word read by the reserving load |
| sc_ok | output | 1 | Conditional store success flag |

## Verification
The bench uses the default ADDR_W and DATA_W of 32. At these widths, negative offsets in both immediate layouts exercise the sign extension across the full address width. A 16-word memory model that answers every request one cycle late exposes the request-hold rule and the locked read-then-write pair. Memory pokes between a load and a store, and cancel pulses (one of them timed onto the completing read), reach the compare-fail and cancel-priority cases.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
    localparam int OPC_W  = 6;
    localparam int INSN_W = 26;
    localparam int IMM_W  = 16;
    localparam logic [OPC_W-1:0] OPC_LOAD_RSV  = 6'h1B;
    localparam logic [OPC_W-1:0] OPC_STORE_CND = 6'h33;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LD_RD,
        ST_SC_RD,
        ST_SC_WR,
        ST_FIN
    } lrsc_state_e;
endpackage

// File: rtl/lrsc_agu.sv
module lrsc_agu
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              is_store,
    input  logic [ADDR_W-1:0] base,
    input  logic [INSN_W-1:0] insn,
    output logic [ADDR_W-1:0] addr
);
    localparam int EXT_W = ADDR_W - IMM_W;

    logic [IMM_W-1:0]  ofs;
    logic [ADDR_W-1:0] ofs_ext;

    always_comb begin
        if (is_store) ofs = {insn[25:21], insn[10:0]};
        else          ofs = insn[IMM_W-1:0];
        ofs_ext = {{EXT_W{ofs[IMM_W-1]}}, ofs};
        addr    = base + ofs_ext;
    end
endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cancel,
    input  logic              set,
    input  logic              clr,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic [DATA_W-1:0] set_val,
    output logic [ADDR_W-1:0] rsv_addr,
    output logic [DATA_W-1:0] rsv_val,
    output logic              rsv_valid
);
    localparam logic [ADDR_W-1:0] NONE = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] val;
    } rsv_t;

    rsv_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cancel) begin
            r_d.addr = NONE;
        end else if (set) begin
            r_d.addr = set_addr;
            r_d.val  = set_val;
        end else if (clr) begin
            r_d.addr = NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.addr <= NONE;
            r_q.val  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsv_addr  = r_q.addr;
    assign rsv_val   = r_q.val;
    assign rsv_valid = (r_q.addr != NONE);

    assert_cancel_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !rsv_valid);
    assert_store_ends_rsv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !rsv_valid);
    assert_load_records_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !cancel) |=> (rsv_addr == $past(set_addr)) && (rsv_val == $past(set_val)));
endmodule

// File: rtl/lrsc_ctrl.sv
module lrsc_ctrl
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [OPC_W-1:0]  req_opcode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] rsv_addr,
    input  logic [DATA_W-1:0] rsv_val,
    input  logic              rsv_valid,
    output logic              rsv_set,
    output logic              rsv_clr,
    output logic [ADDR_W-1:0] rsv_set_addr,
    output logic [DATA_W-1:0] rsv_set_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [DATA_W-1:0] ld_data,
    output logic              sc_ok
);
    typedef struct packed {
        lrsc_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              flag;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        rsv_set = 1'b0;
        rsv_clr = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (req_valid && req_opcode == OPC_LOAD_RSV) begin
                    c_d.st   = ST_LD_RD;
                    c_d.addr = req_addr;
                end else if (req_valid && req_opcode == OPC_STORE_CND) begin
                    c_d.addr  = req_addr;
                    c_d.wdata = req_wdata;
                    if (rsv_valid && req_addr == rsv_addr) begin
                        c_d.st = ST_SC_RD;
                    end else begin
                        c_d.st   = ST_FIN;
                        c_d.flag = 1'b0;
                        rsv_clr  = 1'b1;
                    end
                end
            end
            ST_LD_RD: begin
                if (mem_ready) begin
                    c_d.st    = ST_FIN;
                    c_d.rdata = mem_rdata;
                    c_d.flag  = 1'b0;
                    rsv_set   = 1'b1;
                end
            end
            ST_SC_RD: begin
                if (mem_ready) begin
                    if (mem_rdata == rsv_val) begin
                        c_d.st = ST_SC_WR;
                    end else begin
                        c_d.st   = ST_FIN;
                        c_d.flag = 1'b0;
                        rsv_clr  = 1'b1;
                    end
                end
            end
            ST_SC_WR: begin
                if (mem_ready) begin
                    c_d.st   = ST_FIN;
                    c_d.flag = 1'b1;
                    rsv_clr  = 1'b1;
                end
            end
            ST_FIN:  c_d.st = ST_IDLE;
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st    <= ST_IDLE;
            c_q.addr  <= '0;
            c_q.wdata <= '0;
            c_q.rdata <= '0;
            c_q.flag  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rsv_set_addr = c_q.addr;
    assign rsv_set_val  = mem_rdata;
    assign req_ready    = (c_q.st == ST_IDLE);
    assign mem_req      = (c_q.st == ST_LD_RD) || (c_q.st == ST_SC_RD) || (c_q.st == ST_SC_WR);
    assign mem_we       = (c_q.st == ST_SC_WR);
    assign mem_lock     = (c_q.st == ST_SC_RD) || (c_q.st == ST_SC_WR);
    assign mem_addr     = c_q.addr;
    assign mem_wdata    = c_q.wdata;
    assign done         = (c_q.st == ST_FIN);
    assign ld_data      = c_q.rdata;
    assign sc_ok        = c_q.flag;

    assert_write_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_lock);
    assert_write_follows_locked_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_lock) && $past(mem_req));
    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || mem_req) |-> !req_ready);
endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [5:0]        req_opcode,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [25:0]       req_insn,
    input  logic              exc_enter,
    input  logic              exc_return,
    input  logic              mmu_fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [DATA_W-1:0] ld_data,
    output logic              sc_ok
);
    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] rsv_addr, rsv_set_addr;
    logic [DATA_W-1:0] rsv_val, rsv_set_val;
    logic              rsv_valid, rsv_set, rsv_clr, cancel;

    assign cancel = exc_enter | exc_return | mmu_fault;

    lrsc_agu #(.ADDR_W(ADDR_W)) u_agu (
        .is_store (req_opcode == OPC_STORE_CND),
        .base     (req_base),
        .insn     (req_insn),
        .addr     (eff_addr)
    );

    lrsc_resv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .cancel    (cancel),
        .set       (rsv_set),
        .clr       (rsv_clr),
        .set_addr  (rsv_set_addr),
        .set_val   (rsv_set_val),
        .rsv_addr  (rsv_addr),
        .rsv_val   (rsv_val),
        .rsv_valid (rsv_valid)
    );

    lrsc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_opcode   (req_opcode),
        .req_addr     (eff_addr),
        .req_wdata    (req_wdata),
        .req_ready    (req_ready),
        .rsv_addr     (rsv_addr),
        .rsv_val      (rsv_val),
        .rsv_valid    (rsv_valid),
        .rsv_set      (rsv_set),
        .rsv_clr      (rsv_clr),
        .rsv_set_addr (rsv_set_addr),
        .rsv_set_val  (rsv_set_val),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_lock     (mem_lock),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ready    (mem_ready),
        .mem_rdata    (mem_rdata),
        .done         (done),
        .ld_data      (ld_data),
        .sc_ok        (sc_ok)
    );

    assert_no_access_without_rsv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && req_opcode == OPC_STORE_CND && !rsv_valid) |=> !mem_req);
endmodule

// File: tb/lrsc_unit_bench.sv
module lrsc_unit_bench;
    localparam int K_LR = 0, K_SC = 1, K_POKE = 2, K_CAN = 3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] base;
        logic [15:0] ofs;
        logic [31:0] data;
        logic        exp_flag;
        logic [31:0] exp_val;
        logic [1:0]  exp_acc;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 32'h100, 16'h0008, 32'h0,        1'b0, 32'hA0000002, 2'd1},
        '{2'd1, 32'h110, 16'hFFF8, 32'h11111111, 1'b1, 32'h11111111, 2'd2},
        '{2'd1, 32'h110, 16'hFFF8, 32'h22222222, 1'b0, 32'h11111111, 2'd0},
        '{2'd0, 32'h120, 16'hFFF0, 32'h0,        1'b0, 32'hA0000004, 2'd1},
        '{2'd2, 32'h110, 16'h0000, 32'h55555555, 1'b0, 32'h0,        2'd0},
        '{2'd1, 32'h100, 16'h0010, 32'h33333333, 1'b0, 32'h55555555, 2'd1},
        '{2'd0, 32'h100, 16'h0010, 32'h0,        1'b0, 32'h55555555, 2'd1},
        '{2'd1, 32'h100, 16'h0014, 32'h44444444, 1'b0, 32'hA0000005, 2'd0},
        '{2'd1, 32'h100, 16'h0010, 32'h33333333, 1'b0, 32'h55555555, 2'd0},
        '{2'd0, 32'h10C, 16'h0000, 32'h0,        1'b0, 32'hA0000003, 2'd1},
        '{2'd3, 32'h0,   16'h0000, 32'h0,        1'b0, 32'h0,        2'd0},
        '{2'd1, 32'h10C, 16'h0000, 32'h66666666, 1'b0, 32'hA0000003, 2'd0},
        '{2'd0, 32'h10C, 16'h0000, 32'h0,        1'b0, 32'hA0000003, 2'd1},
        '{2'd3, 32'h0,   16'h0000, 32'h1,        1'b0, 32'h0,        2'd0},
        '{2'd1, 32'h10C, 16'h0000, 32'h66666666, 1'b0, 32'hA0000003, 2'd0},
        '{2'd0, 32'h10C, 16'h0000, 32'h0,        1'b0, 32'hA0000003, 2'd1},
        '{2'd3, 32'h0,   16'h0000, 32'h2,        1'b0, 32'h0,        2'd0},
        '{2'd1, 32'h10C, 16'h0000, 32'h66666666, 1'b0, 32'hA0000003, 2'd0},
        '{2'd0, 32'h140, 16'hFFFC, 32'h0,        1'b0, 32'hA000000F, 2'd1},
        '{2'd1, 32'h13C, 16'h0000, 32'h77777777, 1'b1, 32'h77777777, 2'd2},
        '{2'd0, 32'h13C, 16'h0000, 32'h0,        1'b0, 32'h77777777, 2'd1}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [5:0]  req_opcode = '0;
    logic [31:0] req_base = '0, req_wdata = '0;
    logic [25:0] req_insn = '0;
    logic        exc_enter = 1'b0, exc_return = 1'b0, mmu_fault = 1'b0;
    logic        mem_req, mem_we, mem_lock, mem_ready, done, sc_ok;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, ld_data;
    logic [31:0] mem [16];
    int          acc_cnt, n_chk, n_fail;

    always #10 clk = ~clk;

    lrsc_unit u_lrsc_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_base(req_base), .req_wdata(req_wdata),
        .req_insn(req_insn), .exc_enter(exc_enter), .exc_return(exc_return),
        .mmu_fault(mmu_fault), .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .done(done), .ld_data(ld_data), .sc_ok(sc_ok)
    );

    assign mem_rdata = mem[mem_addr[5:2]];

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
        end else if (mem_req && mem_ready) begin
            if (mem_we) mem[mem_addr[5:2]] <= mem_wdata;
            mem_ready <= 1'b0;
            acc_cnt = acc_cnt + 1;
        end else if (mem_req) begin
            mem_ready <= 1'b1;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [25:0] ld_insn(input logic [15:0] o);
        return {10'b0, o};
    endfunction

    function automatic logic [25:0] st_insn(input logic [15:0] o);
        return {o[15:11], 10'b0, o[10:0]};
    endfunction

    task automatic run_op(input logic [5:0] opc, input logic [31:0] base, input logic [25:0] insn,
                          input logic [31:0] wd, output logic got_done, output logic flag,
                          output logic [31:0] rd, output int acc, output logic pulse_ok);
        acc_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_opcode = opc; req_base = base; req_insn = insn; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        got_done = 1'b0; flag = 1'b0; rd = '0; pulse_ok = 1'b1;
        for (int i = 0; i < 12; i++) begin
            if (done) begin got_done = 1'b1; break; end
            @(negedge clk);
        end
        if (got_done) begin
            flag = sc_ok; rd = ld_data;
            @(negedge clk);
            pulse_ok = !done && req_ready;
        end
        acc = acc_cnt;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic gd, fl, po;
        logic [31:0] rd;
        int ac;
        n_chk = 0; n_fail = 0; acc_cnt = 0;
        for (int i = 0; i < 16; i++) mem[i] = 32'hA0000000 + i;
        repeat (3) @(negedge clk);
        check(req_ready && !done && !mem_req, "R10 reset idle", {29'b0, req_ready, done, mem_req}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            vec_t t = VEC[v];
            logic [31:0] a = t.base + {{16{t.ofs[15]}}, t.ofs};
            if (t.kind == K_POKE) begin
                @(negedge clk); mem[a[5:2]] = t.data;
            end else if (t.kind == K_CAN) begin
                @(negedge clk);
                exc_enter = (t.data == 0); exc_return = (t.data == 1); mmu_fault = (t.data == 2);
                @(negedge clk);
                exc_enter = 1'b0; exc_return = 1'b0; mmu_fault = 1'b0;
            end else if (t.kind == K_LR) begin
                run_op(6'h1B, t.base, ld_insn(t.ofs), 32'h0, gd, fl, rd, ac, po);
                check(gd && po, "R10 load done pulse", {31'b0, gd}, 32'h1);
                check(rd == t.exp_val, "R2 load data", rd, t.exp_val);
                check(ac == int'(t.exp_acc), "R2 load transfers", ac, t.exp_acc);
            end else begin
                run_op(6'h33, t.base, st_insn(t.ofs), t.data, gd, fl, rd, ac, po);
                check(gd && po, "R10 store done pulse", {31'b0, gd}, 32'h1);
                check(fl == t.exp_flag, "R6 R7 R8 R9 store flag", fl, t.exp_flag);
                check(ac == int'(t.exp_acc), "R5 R6 R7 store transfers", ac, t.exp_acc);
                check(mem[a[5:2]] == t.exp_val, "R4 R6 R7 memory word", mem[a[5:2]], t.exp_val);
            end
        end

        // R1: unknown opcode ignored, reservation kept
        run_op(6'h1B, 32'h100, ld_insn(16'h0), 32'h0, gd, fl, rd, ac, po);
        run_op(6'h21, 32'h100, ld_insn(16'h0), 32'h0, gd, fl, rd, ac, po);
        check(!gd, "R1 no done for other opcode", {31'b0, gd}, 32'h0);
        check(ac == 0, "R1 no transfer for other opcode", ac, 0);
        run_op(6'h33, 32'h100, st_insn(16'h0), 32'hCAFE0001, gd, fl, rd, ac, po);
        check(fl == 1'b1, "R1 reservation kept", {31'b0, fl}, 32'h1);

        // R9: cancel on the cycle the reserving read completes
        acc_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_opcode = 6'h1B; req_base = 32'h104; req_insn = ld_insn(16'h0);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 10 && !(mem_req && mem_ready); i++) @(negedge clk);
        mmu_fault = 1'b1;
        @(negedge clk);
        mmu_fault = 1'b0;
        repeat (3) @(negedge clk);
        run_op(6'h33, 32'h104, st_insn(16'h0), 32'hBEEF0000, gd, fl, rd, ac, po);
        check(fl == 1'b0, "R9 same-cycle cancel flag", {31'b0, fl}, 32'h0);
        check(ac == 0, "R9 same-cycle cancel transfers", ac, 0);

        // R9: reset clears reservation
        run_op(6'h1B, 32'h108, ld_insn(16'h0), 32'h0, gd, fl, rd, ac, po);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(req_ready && !done && !mem_req, "R10 idle in reset", {29'b0, req_ready, done, mem_req}, 32'h4);
        rst_n = 1'b1;
        run_op(6'h33, 32'h108, st_insn(16'h0), 32'hBEEF0001, gd, fl, rd, ac, po);
        check(fl == 1'b0 && ac == 0, "R9 reset cancels", {31'b0, fl}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule